// File: doc/BRIEF.md
# Programmable Local Bus Strobe Timer

This block produces the control strobes for a single access on a slow peripheral bus. A host-side data-phase request (active low, in the style of a PCI initiator-ready signal) starts an access. The block then counts clock cycles from a reference cycle that falls two clocks after the request. Each edge of each strobe is placed at its own 4-bit count, held in a 24-bit configuration register.

Two bus styles are supported. In the separate-strobe style (Intel-like), the chip selects and a read strobe are driven, with separate chip-select windows for reads and writes. In the direction-line style (Motorola-like), the chip selects stay idle, the data strobes carry the read timing, and a read-not-write line is pulled low at the start of writes and released at a programmed count. The chip selects and data strobes are replicated across lanes, and per-lane enables captured with the request choose which lanes move. A one-cycle done pulse marks the end of each access.

Top module: `lbus_strobe_timer`

## Requirements
- R1: While reset is held and after it is released, every cs_n and ds_n line, rd_n and rnw are high and done is low.
- R2: An access starts when req_n is sampled low while idle after being sampled high. Call the cycle after that edge tick 0. The reference cycle is tick 1 (two clocks after the request), and offset o = tick - 1. moto_mode, wr_op, cs_sel and lane_en are captured at the start edge.
- R3: In the separate-strobe style, a read drives cs_n to ~cs_sel for offsets in [cfg[3:0], cfg[7:4]) and drives rd_n low for offsets in [cfg[19:16], cfg[23:20]). ds_n and rnw stay high.
- R4: In the separate-strobe style, a write drives cs_n to ~cs_sel for offsets in [cfg[11:8], cfg[15:12]). rd_n, ds_n and rnw stay high.
- R5: In the direction-line style, cs_n and rd_n stay high. A read drives ds_n to ~lane_en for offsets in [cfg[19:16], cfg[23:20]) and keeps rnw high.
- R6: In the direction-line style, a write drives rnw low for offsets in [0, cfg[15:12]) and keeps ds_n high.
- R7: If a window's end count is at or below its start count, that strobe does not assert during the access, and the access still completes.
- R8: done is high for exactly the one cycle at offset E+1. E is cfg[15:12] for writes, cfg[23:20] for direction-line reads, and the larger of cfg[7:4] and cfg[23:20] for separate-strobe reads. From the next cycle the block is idle with all strobes high.
- R9: A cfg_we pulse while idle loads cfg_wdata at that edge. A pulse during an access is dropped and does not affect the current or later accesses.
- R10: Reset loads the fields {[3:0],[7:4],[11:8],[15:12],[19:16],[23:20]} as {0,3,0,2,0,3} when ALT_PROFILE=0, and as {0,2,0,2,1,2} when ALT_PROFILE=1.
- R11: If req_n is held low through the end of an access, no new access starts. req_n must be seen high again first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | 1 | Active-low data-phase request |
| moto_mode | input | 1 | 1 selects the direction-line style, 0 the separate-strobe style |
| wr_op | input | 1 | 1 for a write access, 0 for a read |
| cs_sel | input | NUM_CS | Chip-select lanes to drive during the access |
| lane_en | input | NUM_DS | Data-strobe lanes to drive during the access |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 24 | Configuration write data, six 4-bit counts |
| cs_n | output | NUM_CS | Active-low chip selects |
| rd_n | output | 1 | Active-low read strobe |
| ds_n | output | NUM_DS | Active-low data strobes |
| rnw | output | 1 | Read-not-write line, low during the write window |
| done | output | 1 | One-cycle end-of-access pulse |

## Verification
The bench builds two copies with NUM_CS=3 and NUM_DS=2, one with ALT_PROFILE=0 and one with ALT_PROFILE=1, and drives both with the same stimulus. The lane widths differ from each other, so a lane select applied to the wrong bus shows up as a mismatch. The two default profiles end their reads on different cycles. As a result, one copy sits idle with req_n still low while the other is still running, which exercises the no-retrigger rule under both profiles. Random counts, including equal, inverted, zero and full-scale windows, reach the suppressed-strobe and shortest-access corners.

// File: rtl/lbst_pkg.sv
`timescale 1ns/1ps
package lbst_pkg;
  localparam int FIELD_W = 4;
  localparam int CFG_W   = 6 * FIELD_W;
  localparam int TICK_W  = FIELD_W + 1;

  // Packed from the top bit down: read strobe end/start, write cs end/start, read cs end/start
  typedef struct packed {
    logic [FIELD_W-1:0] rd_off;
    logic [FIELD_W-1:0] rd_on;
    logic [FIELD_W-1:0] wcs_off;
    logic [FIELD_W-1:0] wcs_on;
    logic [FIELD_W-1:0] rcs_off;
    logic [FIELD_W-1:0] rcs_on;
  } lbst_cfg_t;

  function automatic lbst_cfg_t cfg_default(input bit alt);
    lbst_cfg_t c;
    c.rcs_on  = FIELD_W'(0);
    c.rcs_off = alt ? FIELD_W'(2) : FIELD_W'(3);
    c.wcs_on  = FIELD_W'(0);
    c.wcs_off = FIELD_W'(2);
    c.rd_on   = alt ? FIELD_W'(1) : FIELD_W'(0);
    c.rd_off  = alt ? FIELD_W'(2) : FIELD_W'(3);
    return c;
  endfunction

  // Is the offset (tick-1) inside the half-open window [t_on, t_off)?
  function automatic logic win_on(input logic [FIELD_W-1:0] t_on,
                                  input logic [FIELD_W-1:0] t_off,
                                  input logic [TICK_W-1:0]  tick);
    logic [TICK_W-1:0] off;
    off = tick - TICK_W'(1);
    return (tick != '0) && (off >= TICK_W'(t_on)) && (off < TICK_W'(t_off));
  endfunction

  // Tick on which the access ends and done is raised
  function automatic logic [TICK_W-1:0] last_tick(input lbst_cfg_t c,
                                                  input logic moto,
                                                  input logic wr);
    logic [FIELD_W-1:0] m;
    if (wr)        m = c.wcs_off;
    else if (moto) m = c.rd_off;
    else           m = (c.rcs_off > c.rd_off) ? c.rcs_off : c.rd_off;
    return TICK_W'(m) + TICK_W'(2);
  endfunction
endpackage

// File: rtl/lbst_cfg.sv
`timescale 1ns/1ps
module lbst_cfg
  import lbst_pkg::*;
#(
  parameter bit ALT_PROFILE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output lbst_cfg_t        cfg
);
  lbst_cfg_t cfg_q;
  logic      take;

  assign take = we && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg_q <= cfg_default(ALT_PROFILE);
    else if (take) cfg_q <= lbst_cfg_t'(wdata);
  end

  assign cfg = cfg_q;

  // R9: the counts stay frozen across an access
  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cfg_q));
  // R9: an idle write lands on the next edge
  p_cfg_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !busy) |=> (cfg_q == $past(wdata)));
endmodule

// File: rtl/lbst_seq.sv
`timescale 1ns/1ps
module lbst_seq
  import lbst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_n,
  input  logic              moto_in,
  input  logic              wr_in,
  input  lbst_cfg_t         cfg,
  output logic              busy,
  output logic              start,
  output logic [TICK_W-1:0] tick,
  output logic              op_moto,
  output logic              op_wr,
  output logic              done
);
  logic              req_q;
  logic [TICK_W-1:0] end_tick;

  assign end_tick = last_tick(cfg, op_moto, op_wr);
  assign start    = !busy && !req_n && req_q;
  assign done     = busy && (tick == end_tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b1;
    else        req_q <= req_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      tick    <= '0;
      op_moto <= 1'b0;
      op_wr   <= 1'b0;
    end else if (start) begin
      busy    <= 1'b1;
      tick    <= '0;
      op_moto <= moto_in;
      op_wr   <= wr_in;
    end else if (busy) begin
      if (done) busy <= 1'b0;
      else      tick <= tick + TICK_W'(1);
    end
  end

  // R2: a start leads to tick 0 on the next cycle
  p_start_tick0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && tick == '0));
  // R8: done lasts one cycle and returns the block to idle
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  // R8: the counter never runs past the end tick
  p_tick_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (tick <= end_tick));
  // R11: a request held low from the previous cycle never starts an access
  p_held_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!req_n) && !req_n) |-> !start);
endmodule

// File: rtl/lbst_window.sv
`timescale 1ns/1ps
module lbst_window
  import lbst_pkg::*;
#(
  parameter int LANES = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               busy,
  input  logic               gate,
  input  logic [LANES-1:0]   lane_sel,
  input  logic [FIELD_W-1:0] t_on,
  input  logic [FIELD_W-1:0] t_off,
  input  logic [TICK_W-1:0]  tick,
  output logic [LANES-1:0]   line_n
);
  logic hit;

  assign hit = busy && gate && win_on(t_on, t_off, tick);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign line_n[g] = !(hit && lane_sel[g]);
  end

  // R7: an empty or inverted window keeps every lane high
  p_empty_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (t_off <= t_on) |-> (&line_n));
  // R8: nothing drives low while idle
  p_idle_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (&line_n));
endmodule

// File: rtl/lbus_strobe_timer.sv
`timescale 1ns/1ps
module lbus_strobe_timer
  import lbst_pkg::*;
#(
  parameter int NUM_CS      = 4,
  parameter int NUM_DS      = 4,
  parameter bit ALT_PROFILE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_n,
  input  logic              moto_mode,
  input  logic              wr_op,
  input  logic [NUM_CS-1:0] cs_sel,
  input  logic [NUM_DS-1:0] lane_en,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [NUM_CS-1:0] cs_n,
  output logic              rd_n,
  output logic [NUM_DS-1:0] ds_n,
  output logic              rnw,
  output logic              done
);
  lbst_cfg_t          cfg;
  logic               busy, start, op_moto, op_wr;
  logic [TICK_W-1:0]  tick;
  logic [NUM_CS-1:0]  cs_sel_q;
  logic [NUM_DS-1:0]  lane_q;
  logic [FIELD_W-1:0] cs_on, cs_off;
  logic               rd_line, rnw_line;

  lbst_cfg #(.ALT_PROFILE(ALT_PROFILE)) u_cfg (
    .clk(clk), .rst_n(rst_n), .busy(busy), .we(cfg_we), .wdata(cfg_wdata), .cfg(cfg)
  );

  lbst_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .moto_in(moto_mode), .wr_in(wr_op),
    .cfg(cfg), .busy(busy), .start(start), .tick(tick),
    .op_moto(op_moto), .op_wr(op_wr), .done(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sel_q <= '0;
      lane_q   <= '0;
    end else if (start) begin
      cs_sel_q <= cs_sel;
      lane_q   <= lane_en;
    end
  end

  assign cs_on  = op_wr ? cfg.wcs_on  : cfg.rcs_on;
  assign cs_off = op_wr ? cfg.wcs_off : cfg.rcs_off;

  lbst_window #(.LANES(NUM_CS)) u_cs (
    .clk(clk), .rst_n(rst_n), .busy(busy), .gate(!op_moto), .lane_sel(cs_sel_q),
    .t_on(cs_on), .t_off(cs_off), .tick(tick), .line_n(cs_n)
  );

  lbst_window #(.LANES(1)) u_rd (
    .clk(clk), .rst_n(rst_n), .busy(busy), .gate(!op_moto && !op_wr), .lane_sel(1'b1),
    .t_on(cfg.rd_on), .t_off(cfg.rd_off), .tick(tick), .line_n(rd_line)
  );

  lbst_window #(.LANES(NUM_DS)) u_ds (
    .clk(clk), .rst_n(rst_n), .busy(busy), .gate(op_moto && !op_wr), .lane_sel(lane_q),
    .t_on(cfg.rd_on), .t_off(cfg.rd_off), .tick(tick), .line_n(ds_n)
  );

  lbst_window #(.LANES(1)) u_rnw (
    .clk(clk), .rst_n(rst_n), .busy(busy), .gate(op_moto && op_wr), .lane_sel(1'b1),
    .t_on(FIELD_W'(0)), .t_off(cfg.wcs_off), .tick(tick), .line_n(rnw_line)
  );

  assign rd_n = rd_line;
  assign rnw  = rnw_line;

  // R5: the direction-line style never touches the chip selects or the read strobe
  p_moto_cs_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_moto) |-> ((&cs_n) && rd_n));
  // R3: the separate-strobe style leaves the data strobes and direction line idle
  p_intel_ds_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !op_moto) |-> ((&ds_n) && rnw));
  // R6: reads keep the direction line high
  p_read_rnw_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !op_wr) |-> rnw);
  // R4: writes never pulse the read strobes
  p_write_no_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_wr) |-> (rd_n && (&ds_n)));
  // R1: idle outputs are all inactive
  p_idle_outputs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ((&cs_n) && rd_n && (&ds_n) && rnw && !done));
endmodule

// File: tb/test_lbus_strobe_timer.sv
`timescale 1ns/1ps
module test_lbus_strobe_timer;
  localparam int NCS = 3;
  localparam int NDS = 2;
  localparam int VW  = NCS + NDS + 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic           rst_n, req_n, moto, wr, cfg_we;
  logic [NCS-1:0] sel;
  logic [NDS-1:0] be;
  logic [23:0]    cfg_wdata;

  logic [NCS-1:0] cs0, cs1;
  logic [NDS-1:0] ds0, ds1;
  logic           rd0, rd1, rnw0, rnw1, dn0, dn1;

  lbus_strobe_timer #(.NUM_CS(NCS), .NUM_DS(NDS), .ALT_PROFILE(1'b0)) i_lbus_strobe_timer (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .moto_mode(moto), .wr_op(wr),
    .cs_sel(sel), .lane_en(be), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cs_n(cs0), .rd_n(rd0), .ds_n(ds0), .rnw(rnw0), .done(dn0));

  lbus_strobe_timer #(.NUM_CS(NCS), .NUM_DS(NDS), .ALT_PROFILE(1'b1)) i_lbus_strobe_timer_alt (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .moto_mode(moto), .wr_op(wr),
    .cs_sel(sel), .lane_en(be), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cs_n(cs1), .rd_n(rd1), .ds_n(ds1), .rnw(rnw1), .done(dn1));

  int          n_vec = 0;
  int          n_bad = 0;
  bit          finished = 0;
  logic [23:0] m0, m1;   // bench copies of each configuration

  // R10 defaults: read cs 0..3 / 0..2, write cs 0..2, read strobe 0..3 / 1..2
  localparam logic [23:0] DEF0 = {4'd3, 4'd0, 4'd2, 4'd0, 4'd3, 4'd0};
  localparam logic [23:0] DEF1 = {4'd2, 4'd1, 4'd2, 4'd0, 4'd2, 4'd0};

  function automatic bit in_win(int o, int a, int d);
    return (o >= 0) && (a <= o) && (o < d);
  endfunction

  function automatic int fin_of(logic [23:0] c, logic m, logic w);
    int rcs_d = int'(c[7:4]);
    int rd_d  = int'(c[23:20]);
    int e;
    if (w)      e = int'(c[15:12]);
    else if (m) e = rd_d;
    else        e = (rd_d > rcs_d) ? rd_d : rcs_d;
    return e + 2;
  endfunction

  // Expected {done, rnw, rd_n, ds_n, cs_n} k cycles after the start edge
  function automatic logic [VW-1:0] exp_vec(logic [23:0] c, logic m, logic w,
                                           logic [NCS-1:0] s, logic [NDS-1:0] b, int k);
    logic [NCS-1:0] ecs = '1;
    logic [NDS-1:0] eds = '1;
    logic erd = 1'b1, ernw = 1'b1, edn = 1'b0;
    int o = k - 1;
    int fin = fin_of(c, m, w);
    if (k <= fin) begin
      edn = (k == fin);
      if (!m && !w && in_win(o, int'(c[3:0]),   int'(c[7:4])))   ecs = ~s;
      if (!m &&  w && in_win(o, int'(c[11:8]),  int'(c[15:12]))) ecs = ~s;
      if (!m && !w && in_win(o, int'(c[19:16]), int'(c[23:20]))) erd = 1'b0;
      if ( m && !w && in_win(o, int'(c[19:16]), int'(c[23:20]))) eds = ~b;
      if ( m &&  w && in_win(o, 0,              int'(c[15:12]))) ernw = 1'b0;
    end
    return {edn, ernw, erd, eds, ecs};
  endfunction

  task automatic cmp(string tag, int k, logic [VW-1:0] got, logic [VW-1:0] exp, int inst);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s inst%0d k=%0d got %b expected %b", tag, inst, k, got, exp);
    end
  endtask

  task automatic check_k(string tag, logic m, logic w, logic [NCS-1:0] s, logic [NDS-1:0] b, int k);
    cmp(tag, k, {dn0, rnw0, rd0, ds0, cs0}, exp_vec(m0, m, w, s, b, k), 0);
    cmp(tag, k, {dn1, rnw1, rd1, ds1, cs1}, exp_vec(m1, m, w, s, b, k), 1);
  endtask

  function automatic string mode_tag(logic m, logic w);
    if (!m) return w ? "R4" : "R3";
    return w ? "R6" : "R5";
  endfunction

  task automatic write_cfg(logic [23:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    m0 = d; m1 = d;   // R9: an idle write takes effect
  endtask

  // One access; optionally a configuration write attempt in mid-access (R9)
  task automatic access(logic m, logic w, logic [NCS-1:0] s, logic [NDS-1:0] b,
                        bit mid_wr, logic [23:0] mid_data, string extra);
    int f0 = fin_of(m0, m, w);
    int f1 = fin_of(m1, m, w);
    int span = (f0 > f1) ? f0 : f1;
    string tag = {mode_tag(m, w), "/R8/", extra};
    @(negedge clk);
    moto = m; wr = w; sel = s; be = b; req_n = 1'b0;   // R2: request cycle
    for (int k = 0; k <= span + 2; k++) begin
      @(negedge clk);
      check_k(tag, m, w, s, b, k);     // idle cycles with req_n low cover R11
      if (k == 0) begin                // R2: inputs captured at start
        moto = ~m; wr = ~w; sel = ~s; be = ~b;
      end
      if (mid_wr && k == 1) begin cfg_we = 1'b1; cfg_wdata = mid_data; end
      else cfg_we = 1'b0;
    end
    req_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [23:0] rc;
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; req_n = 1'b1; moto = 1'b0; wr = 1'b0; sel = '0; be = '0;
    cfg_we = 1'b0; cfg_wdata = '0;
    m0 = DEF0; m1 = DEF1;
    repeat (3) @(negedge clk);
    check_k("R1", 1'b0, 1'b0, '0, '0, 99);   // R1: idle during reset
    rst_n = 1'b1;
    @(negedge clk);
    check_k("R1", 1'b0, 1'b0, '0, '0, 99);   // R1: idle after reset

    // R10: default profiles in every style/direction
    access(1'b0, 1'b0, 3'b101, 2'b01, 1'b0, '0, "R10");
    access(1'b0, 1'b1, 3'b011, 2'b10, 1'b0, '0, "R10");
    access(1'b1, 1'b0, 3'b111, 2'b10, 1'b0, '0, "R10");
    access(1'b1, 1'b1, 3'b010, 2'b11, 1'b0, '0, "R10");

    // R7: equal and inverted windows, zero-length write
    write_cfg({4'd2, 4'd7, 4'd1, 4'd3, 4'd5, 4'd5});
    access(1'b0, 1'b0, 3'b111, 2'b11, 1'b0, '0, "R7");
    access(1'b0, 1'b1, 3'b111, 2'b11, 1'b0, '0, "R7");
    access(1'b1, 1'b0, 3'b111, 2'b11, 1'b0, '0, "R7");
    write_cfg({4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0});
    access(1'b1, 1'b1, 3'b111, 2'b11, 1'b0, '0, "R7");
    access(1'b0, 1'b0, 3'b111, 2'b11, 1'b0, '0, "R7");

    // Full-scale counts
    write_cfg({4'd15, 4'd14, 4'd15, 4'd0, 4'd15, 4'd1});
    access(1'b0, 1'b0, 3'b110, 2'b01, 1'b0, '0, "R2");
    access(1'b1, 1'b1, 3'b110, 2'b01, 1'b0, '0, "R6");

    // R9: a write attempted during an access is dropped
    write_cfg({4'd4, 4'd1, 4'd3, 4'd1, 4'd4, 4'd2});
    access(1'b0, 1'b0, 3'b001, 2'b01, 1'b1, 24'hFFFFFF, "R9");
    access(1'b1, 1'b0, 3'b001, 2'b11, 1'b0, '0, "R9");
    access(1'b0, 1'b1, 3'b100, 2'b01, 1'b1, 24'h000000, "R9");

    // Random counts and operations
    for (int i = 0; i < 80; i++) begin
      rc = 24'($urandom);
      write_cfg(rc);
      access(1'($urandom), 1'($urandom), NCS'($urandom), NDS'($urandom),
             1'($urandom), 24'($urandom), "RND");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule